// File: doc/BRIEF.md
# Two-Phase Fixed Off-Time PWM Chopper

This block times the gate enables for the two phases of a unipolar stepper driver. Each phase has a current-trip input, which is a digital comparator result already in the system-clock domain, and a 4-bit current-ratio code from the step sequencer. A phase drives its main switch until the trip input is accepted. The trip input is not looked at during a blanking window that opens at every turn-on. The phase then stays off for a fixed time, and the ratio code picks one of three lengths for it. Inside that off-time the opposite-side switch is turned on for synchronous rectification. A dead gap separates it from the main switch on both sides.

A sync input ties the chopping of the phases together: when a trip is accepted on one phase, every phase that is driving starts its off-time on the same edge. A ratio code of zero parks its phase with both switches off. A sleep input parks every phase. All timing constants are parameters counted in system-clock cycles. The comparators, the DAC and the gate drivers sit outside this block.

Top module: `chop_top`

## Requirements
- R1: For the first BLANK cycles of every on-time the trip input has no effect, so the main enable stays high. BLANK is BLANK_CYC, or twice BLANK_CYC when LONG_BLANK is 1.
- R2: A trip that is high at the clock edge ending the blanking window, or at any later edge while the phase is on, drops the main enable from that edge. If trip is held high, the phase therefore stays on for exactly BLANK cycles, and an on-time is never shorter than BLANK unless sync, sleep or code 0 ends it.
- R3: After a trip is accepted, the main enable stays low for OFF cycles and then rises again, with a fresh blanking window. OFF is OFF_SHORT_CYC for code 4'h2, OFF_MID_CYC for codes 4'h4 and 4'h6, and OFF_LONG_CYC for every other nonzero code (8, A, C, E, F and the odd codes). Trip has no effect during the off-time.
- R4: In each off-time the rectifier enable is high for OFF − 2·DEAD_CYC cycles. It starts DEAD_CYC cycles after the main enable falls and ends DEAD_CYC cycles before the main enable rises. The two enables of a phase are never high together.
- R5: The ratio code is sampled at the edge where the trip is accepted. A change during an off-time only affects the next off-time.
- R6: While sync is high, a trip accepted on any phase makes every phase that is driving enter its off-time at that same edge. Each phase uses its own ratio code for the length. While sync is low, the phases chop independently.
- R7: A phase whose ratio code is 4'h0 has both enables low from the next edge. When the code becomes nonzero again, the phase turns on at the next edge with a fresh blanking window.
- R8: While sleep is high, every enable is low from the next edge. After sleep falls, the phases turn on at the next edge with a fresh blanking window.
- R9: While rst_n is low, all enables are low. After release, the phases turn on within a few cycles with the rectifier enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Forces every enable low |
| sync_i | input | 1 | Aligns the off-times of all phases |
| trip_i | input | NUM_PH | Current-trip comparator result per phase |
| ratio_i | input | 4·NUM_PH | Current-ratio code per phase, phase p in bits 4p+3..4p |
| drive_o | output | NUM_PH | Main switch enable per phase |
| rect_o | output | NUM_PH | Synchronous-rectifier enable per phase |

## Verification
The assertions assume a few things about the inputs. Trip, sync, sleep and the ratio codes are synchronous to clk. The parameters satisfy DEAD_CYC ≥ 1, BLANK_CYC ≥ 1 and OFF_SHORT_CYC > 2·DEAD_CYC, so every state lasts at least one cycle. The stimulus changes every input only just after a rising edge and keeps it steady through the next one. It uses only nonzero ratio codes during the random chopping. Sync, sleep and code zero are applied only in directed windows, and the interval monitor is paused during those windows, because those inputs are allowed to cut an on-time short.

// File: rtl/chop_pkg.sv
package chop_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLANK,
    ST_ON,
    ST_DEAD1,
    ST_SR,
    ST_DEAD2
  } ph_state_e;
endpackage

// File: rtl/chop_rst_sync.sv
module chop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/chop_off_sel.sv
module chop_off_sel
  import chop_pkg::*;
#(
  parameter int OFF_LONG_CYC  = 115,
  parameter int OFF_MID_CYC   = 85,
  parameter int OFF_SHORT_CYC = 70,
  parameter int DEAD_CYC      = 5,
  parameter int CW            = 8
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o,
  output logic [CW-1:0]     sr_len_o
);
  localparam int SR_LONG  = OFF_LONG_CYC  - 2 * DEAD_CYC;
  localparam int SR_MID   = OFF_MID_CYC   - 2 * DEAD_CYC;
  localparam int SR_SHORT = OFF_SHORT_CYC - 2 * DEAD_CYC;

  always_comb begin
    en_o     = 1'b1;
    sr_len_o = CW'(SR_LONG);
    case (code_i)
      4'h0: en_o = 1'b0;
      4'h2: sr_len_o = CW'(SR_SHORT);
      4'h4,
      4'h6: sr_len_o = CW'(SR_MID);
      default: sr_len_o = CW'(SR_LONG);
    endcase
  end
endmodule

// File: rtl/chop_phase.sv
module chop_phase
  import chop_pkg::*;
#(
  parameter int BLANK_EFF = 15,
  parameter int DEAD_CYC  = 5,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trip_i,
  input  logic          halt_i,
  input  logic          force_i,
  input  logic [CW-1:0] sr_len_i,
  output logic          accept_o,
  output logic          drive_o,
  output logic          rect_o
);
  ph_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;
  logic          len_en;
  logic          on_side;
  logic          go_off;

  assign on_side  = (st_q == ST_BLANK) || (st_q == ST_ON);
  assign accept_o = !halt_i && trip_i &&
                    ((st_q == ST_ON) || ((st_q == ST_BLANK) && (cnt_q == '0)));
  assign go_off   = accept_o || (force_i && on_side && !halt_i);
  assign len_en   = go_off;
  assign len_d    = sr_len_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (halt_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d  = ST_BLANK;
          cnt_d = CW'(BLANK_EFF - 1);
        end
        ST_BLANK, ST_ON: begin
          if (go_off) begin
            st_d  = ST_DEAD1;
            cnt_d = CW'(DEAD_CYC - 1);
          end else if (st_q == ST_BLANK) begin
            if (cnt_q == '0) st_d = ST_ON;
            else             cnt_d = cnt_q - 1'b1;
          end
        end
        ST_DEAD1: begin
          if (cnt_q == '0) begin
            st_d  = ST_SR;
            cnt_d = len_q - 1'b1;
          end else cnt_d = cnt_q - 1'b1;
        end
        ST_SR: begin
          if (cnt_q == '0) begin
            st_d  = ST_DEAD2;
            cnt_d = CW'(DEAD_CYC - 1);
          end else cnt_d = cnt_q - 1'b1;
        end
        ST_DEAD2: begin
          if (cnt_q == '0) begin
            st_d  = ST_BLANK;
            cnt_d = CW'(BLANK_EFF - 1);
          end else cnt_d = cnt_q - 1'b1;
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  assign drive_o = on_side;
  assign rect_o  = (st_q == ST_SR);

  // on-time length tracker used by the checks below
  logic [CW-1:0] on_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    on_cnt_q <= '0;
    else if (!drive_o)             on_cnt_q <= '0;
    else if (on_cnt_q != {CW{1'b1}}) on_cnt_q <= on_cnt_q + 1'b1;
  end

  // R1
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BLANK && cnt_q != '0 && !force_i && !halt_i) |=> drive_o);

  // R2
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drive_o) && !$past(force_i) && !$past(halt_i)) |-> (on_cnt_q >= CW'(BLANK_EFF)));

  // R4
  dead_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rect_o |=> !drive_o);

  // R4
  dead_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |=> !rect_o);

  // R6
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && drive_o && !halt_i) |=> (!drive_o && !rect_o));

  // R7 R8
  halt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (!drive_o && !rect_o));
endmodule

// File: rtl/chop_top.sv
module chop_top
  import chop_pkg::*;
#(
  parameter int NUM_PH        = 2,
  parameter int BLANK_CYC     = 15,
  parameter bit LONG_BLANK    = 1'b0,
  parameter int OFF_LONG_CYC  = 115,
  parameter int OFF_MID_CYC   = 85,
  parameter int OFF_SHORT_CYC = 70,
  parameter int DEAD_CYC      = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sleep_i,
  input  logic                       sync_i,
  input  logic [NUM_PH-1:0]          trip_i,
  input  logic [NUM_PH*CODE_W-1:0]   ratio_i,
  output logic [NUM_PH-1:0]          drive_o,
  output logic [NUM_PH-1:0]          rect_o
);
  localparam int BLANK_EFF = LONG_BLANK ? 2 * BLANK_CYC : BLANK_CYC;
  localparam int MAX_T     = (BLANK_EFF > OFF_LONG_CYC) ? BLANK_EFF : OFF_LONG_CYC;
  localparam int CW        = $clog2(MAX_T + 1);

  logic              rst_q_n;
  logic [NUM_PH-1:0] accept;
  logic              force_all;

  chop_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  assign force_all = sync_i && (|accept);

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic          en;
    logic [CW-1:0] sr_len;

    chop_off_sel #(
      .OFF_LONG_CYC  (OFF_LONG_CYC),
      .OFF_MID_CYC   (OFF_MID_CYC),
      .OFF_SHORT_CYC (OFF_SHORT_CYC),
      .DEAD_CYC      (DEAD_CYC),
      .CW            (CW)
    ) i_sel (
      .code_i   (ratio_i[p*CODE_W +: CODE_W]),
      .en_o     (en),
      .sr_len_o (sr_len)
    );

    chop_phase #(
      .BLANK_EFF (BLANK_EFF),
      .DEAD_CYC  (DEAD_CYC),
      .CW        (CW)
    ) i_phase (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .trip_i   (trip_i[p]),
      .halt_i   (sleep_i || !en),
      .force_i  (force_all),
      .sr_len_i (sr_len),
      .accept_o (accept[p]),
      .drive_o  (drive_o[p]),
      .rect_o   (rect_o[p])
    );
  end

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_q_n |-> (drive_o == '0 && rect_o == '0));
endmodule

// File: tb/test_chop_top.sv
module test_chop_top;
  localparam int BLANK = 15;
  localparam int OFF_L = 115;
  localparam int OFF_M = 85;
  localparam int OFF_S = 70;
  localparam int DEAD  = 5;

  logic       clk = 1'b0;
  logic       rst_n, sleep, sync;
  logic [1:0] trip;
  logic [7:0] ratio;
  logic [1:0] drive, rect;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  chop_top #(
    .NUM_PH(2), .BLANK_CYC(BLANK), .LONG_BLANK(1'b0),
    .OFF_LONG_CYC(OFF_L), .OFF_MID_CYC(OFF_M), .OFF_SHORT_CYC(OFF_S), .DEAD_CYC(DEAD)
  ) i_chop_top (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .sync_i(sync),
    .trip_i(trip), .ratio_i(ratio), .drive_o(drive), .rect_o(rect)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int off_len(input logic [3:0] c);
    case (c)
      4'h0: return 0;
      4'h2: return OFF_S;
      4'h4, 4'h6: return OFF_M;
      default: return OFF_L;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // interval monitor, samples at the falling edge
  bit   mon_en = 1'b0;
  bit   exact_on = 1'b0;
  bit   pd [2];
  bit   seen_rise [2];
  bit   seen_fall [2];
  logic [3:0] cprev [2];
  int   on_run [2];
  int   low_run [2];
  int   rect_cnt [2];
  int   rect_first [2];
  int   exp_off [2];

  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      bit d, r;
      d = drive[p];
      r = rect[p];
      if (!mon_en) begin
        seen_rise[p] = 1'b0;
        seen_fall[p] = 1'b0;
      end else begin
        if (d && r) chk(1'b0, "R4 enables overlap", 1, 0);
        if (d && !pd[p]) begin
          if (seen_fall[p]) begin
            chk(low_run[p] == exp_off[p], "R3 R5 off-time length", low_run[p], exp_off[p]);
            chk(rect_cnt[p] == exp_off[p] - 2*DEAD, "R4 rectifier length", rect_cnt[p], exp_off[p] - 2*DEAD);
            chk(rect_first[p] == DEAD + 1, "R4 rectifier start", rect_first[p], DEAD + 1);
          end
          seen_rise[p] = 1'b1;
          seen_fall[p] = 1'b0;
          on_run[p] = 1;
        end else if (!d && pd[p]) begin
          if (seen_rise[p]) begin
            if (exact_on) chk(on_run[p] == BLANK, "R2 on-time with trip held", on_run[p], BLANK);
            else          chk(on_run[p] >= BLANK, "R1 on-time not below blanking", on_run[p], BLANK);
          end
          seen_fall[p] = 1'b1;
          exp_off[p] = off_len(cprev[p]);
          low_run[p] = 1;
          rect_cnt[p] = r ? 1 : 0;
          rect_first[p] = r ? 1 : 0;
        end else if (d) begin
          on_run[p]++;
        end else begin
          low_run[p]++;
          if (r) begin
            rect_cnt[p]++;
            if (rect_first[p] == 0) rect_first[p] = low_run[p];
          end
        end
      end
      pd[p] = d;
      cprev[p] = ratio[p*4 +: 4];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit stayed;
    int n;
    void'($urandom(32'd4711));
    rst_n = 1'b0; sleep = 1'b0; sync = 1'b0; trip = 2'b00; ratio = 8'h88;
    repeat (3) begin
      tick();
      chk(drive == 2'b00 && rect == 2'b00, "R9 quiet in reset", {drive, rect}, 0);
    end
    rst_n = 1'b1;
    repeat (6) tick();
    chk(drive == 2'b11, "R9 turn-on after reset", drive, 3);
    chk(rect == 2'b00, "R9 rectifier low after reset", rect, 0);

    // R2 R3 R4 R5: trip held, codes stepped asynchronously to the chopping
    mon_en = 1'b1;
    exact_on = 1'b1;
    trip = 2'b11;
    foreach (ratio[i]) ;
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: ratio = 8'h42;
        1: ratio = 8'h86;
        2: ratio = 8'hCA;
        3: ratio = 8'hFE;
        4: ratio = 8'h25;
        default: ratio = 8'h6B;
      endcase
      repeat (290) tick();
    end

    // random chopping, sync low
    exact_on = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      trip[0] = ($urandom % 12) == 0;
      trip[1] = ($urandom % 9) == 0;
      if ((c % 37) == 0) ratio[3:0] = 4'(($urandom % 15) + 1);
      if ((c % 53) == 0) ratio[7:4] = 4'(($urandom % 15) + 1);
      tick();
    end
    trip = 2'b00;
    ratio = 8'h88;

    // R1: trip high through most of a blanking window is ignored
    trip[0] = 1'b1;
    while (drive[0]) tick();
    while (!drive[0]) tick();
    repeat (9) tick();
    trip[0] = 1'b0;
    stayed = 1'b1;
    repeat (40) begin
      tick();
      if (!drive[0]) stayed = 1'b0;
    end
    chk(stayed, "R1 trip in blanking ignored", stayed, 1);

    // R2: trip after the window is accepted at the next edge
    trip[0] = 1'b1;
    tick();
    chk(drive[0] == 1'b0, "R2 trip accepted at next edge", drive[0], 0);
    trip[0] = 1'b0;
    repeat (300) tick();

    // R6: sync aligns both phases
    sync = 1'b1;
    trip[0] = 1'b1;
    tick();
    chk(drive == 2'b00, "R6 sync starts both off-times", drive, 0);
    trip[0] = 1'b0;
    repeat (300) tick();
    sync = 1'b0;
    trip[0] = 1'b1;
    tick();
    chk(drive == 2'b10, "R6 no alignment with sync low", drive, 2);
    trip[0] = 1'b0;
    repeat (300) tick();

    // R7: code 0 parks phase 1
    mon_en = 1'b0;
    ratio[7:4] = 4'h0;
    tick();
    chk(drive[1] == 1'b0 && rect[1] == 1'b0, "R7 code zero parks phase", {drive[1], rect[1]}, 0);
    stayed = 1'b1;
    for (int c = 0; c < 300; c++) begin
      trip[0] = ($urandom % 10) == 0;
      trip[1] = 1'b1;
      tick();
      if (drive[1] || rect[1]) stayed = 1'b0;
    end
    chk(stayed, "R7 parked phase stays off", stayed, 1);
    trip = 2'b00;
    ratio[7:4] = 4'h8;
    trip[1] = 1'b1;
    tick();
    n = 0;
    while (drive[1]) begin n++; tick(); end
    chk(n == BLANK, "R7 resume with blanking", n, BLANK);
    trip = 2'b00;
    repeat (300) tick();

    // R8: sleep parks everything
    sleep = 1'b1;
    tick();
    chk(drive == 2'b00 && rect == 2'b00, "R8 sleep forces low", {drive, rect}, 0);
    stayed = 1'b1;
    repeat (50) begin
      tick();
      if (drive != 2'b00 || rect != 2'b00) stayed = 1'b0;
    end
    chk(stayed, "R8 sleep holds low", stayed, 1);
    trip = 2'b11;
    sleep = 1'b0;
    tick();
    n = 0;
    while (drive[0]) begin n++; tick(); end
    chk(n == BLANK, "R8 resume with blanking", n, BLANK);
    trip = 2'b00;
    repeat (20) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule